// File: doc/BRIEF.md
# Strobed Nine-Bit FIFO with Rewind and Chain Token

A first-in first-out buffer for 9-bit words whose depth is a power of two set by a parameter. Writers and readers use active-low strobes. The block samples both strobes on a single clock, and each falling edge of a strobe moves exactly one word. Words come out in the order they went in. The block flags when it is empty, full or at least half full. The read data is modelled as a data bus plus an output enable that is high only while the read strobe is low.

The block has two configurations, chosen by a mode input. In solo mode, the shared status pin carries the half-full flag. A rewind input moves the read side back to address zero, so that every word written since reset can be read again. In chained mode, several buffers are cascaded in depth. The shared pin then carries a one-cycle token when the write address wraps from the last location to zero, which tells the next buffer in the chain to take over. Rewind is ignored in chained mode.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `empty` is 1, `full` is 0, `stat_pin` is 0 and `dout_oe` is 0.
- R2: A write is stored when `wr_n` is sampled low and was sampled high on the previous clock edge. Holding `wr_n` low for further cycles stores nothing more, even if `din` changes.
- R3: Words are read out in the order they were written. The read word is presented on `dout` one clock edge after the falling edge of `rd_n` is sampled.
- R4: `dout_oe` is 1 in the cycle after an edge at which `rd_n` was sampled low, and 0 in the cycle after an edge at which it was sampled high. While `dout_oe` is 0, `dout` is all zeros.
- R5: `empty` and `full` are never high together. A write strobe while `full` is high stores nothing, and `full` stays high.
- R6: A read strobe while `empty` is high does not advance the read side. `empty` stays high, and the next word written is the next word read.
- R7: With `chain_mode` = 0, `stat_pin` is 1 exactly when the occupancy is at least DEPTH/2.
- R8: With `chain_mode` = 0, `rt_n` sampled low while `wr_n` and `rd_n` are both high sets the read address to 0 and the occupancy to the current write address. The write address is unchanged, so later writes follow the old data.
- R9: The rewind has no effect if `wr_n` or `rd_n` is low in the same cycle, or if `chain_mode` = 1.
- R10: With `chain_mode` = 1, `stat_pin` is high for exactly one cycle, following the write that stores into the last address (DEPTH-1). It does not show the half-full state.
- R11: A read strobe and a write strobe on the same edge leave the occupancy unchanged. The read returns the oldest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| chain_mode | input | 1 | 0 = solo (half flag, rewind enabled), 1 = depth-chained (token output) |
| wr_n | input | 1 | Write strobe, active low, falling edge stores `din` |
| rd_n | input | 1 | Read strobe, active low, falling edge pops a word |
| rt_n | input | 1 | Rewind request, active low, solo mode only |
| din | input | 9 | Write data |
| dout | output | 9 | Read data, zero while not enabled |
| dout_oe | output | 1 | Output enable, follows `rd_n` low with one cycle delay |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| stat_pin | output | 1 | Half-full flag in solo mode, wrap token in chained mode |

## Verification
Every result is one clock edge behind the strobe that causes it. The edge that first samples a low strobe also writes the data register, the occupancy count, the token and the enable register. The flags are decoded straight from the count, so they change at that same edge. The bench drives inputs on falling clock edges and reads the outputs at the next falling edge. After each strobe pulse, the read data, the enable and the flags are all checked in the half-cycle after the edge that updated them. The token check also looks one further cycle ahead to confirm that the pulse has ended.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    localparam int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_SOLO  = 1'b0,
        MODE_CHAIN = 1'b1
    } fifo_mode_e;

    // Strobe events after edge detection, before qualification by flags
    typedef struct packed {
        logic push;
        logic pop;
        logic rewind;
    } fifo_req_s;

    // Falling edge of an active-low level between two samples
    function automatic logic went_low(input logic prev_lvl, input logic now_lvl);
        return prev_lvl & ~now_lvl;
    endfunction

endpackage

// File: rtl/strobe_sense.sv
module strobe_sense
    import strobe_fifo_pkg::*;
#(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] lvl_n,
    output logic [NUM-1:0] fall
);

    for (genvar i = 0; i < NUM; i++) begin : g_lane
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b1;
            else     prev_q <= lvl_n[i];
        end

        assign fall[i] = went_low(prev_q, lvl_n[i]);
    end

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  fifo_mode_e        mode,
    input  fifo_req_s         req,
    output logic              wr_en,
    output logic              rd_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              is_empty,
    output logic              is_full,
    output logic              is_half,
    output logic              wrap_tok
);

    localparam int CNT_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DEPTH / 2);
    localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              tok_q;
    logic              rew_go;

    assign is_empty = (cnt_q == '0);
    assign is_full  = (cnt_q == CNT_FULL);
    assign is_half  = (cnt_q >= CNT_HALF);

    assign rew_go = req.rewind && (mode == MODE_SOLO);
    assign wr_en  = req.push && !is_full;
    assign rd_en  = req.pop && !is_empty && !rew_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            tok_q <= 1'b0;
        end else begin
            tok_q <= (mode == MODE_CHAIN) && wr_en && (wp_q == ADDR_LAST);
            if (wr_en) wp_q <= wp_q + ADDR_W'(1);
            if (rew_go) begin
                rp_q  <= '0;
                cnt_q <= {1'b0, wp_q};
            end else begin
                if (rd_en) rp_q <= rp_q + ADDR_W'(1);
                unique case ({wr_en, rd_en})
                    2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                    2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end

    assign wr_addr  = wp_q;
    assign rd_addr  = rp_q;
    assign wrap_tok = tok_q;

endmodule

// File: rtl/fifo_store.sv
module fifo_store
    import strobe_fifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];
    word_t rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= mem[rd_addr];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        chain_mode,
    input  logic        wr_n,
    input  logic        rd_n,
    input  logic        rt_n,
    input  logic [8:0]  din,
    output logic [8:0]  dout,
    output logic        dout_oe,
    output logic        empty,
    output logic        full,
    output logic        stat_pin
);

    fifo_mode_e        mode;
    logic [1:0]        falls;
    fifo_req_s         req;
    logic              wr_en, rd_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              is_half, wrap_tok;
    word_t             rd_data;
    logic              oe_q;

    assign mode = fifo_mode_e'(chain_mode);

    strobe_sense #(.NUM(2)) u_sense (
        .clk   (clk),
        .rst   (rst),
        .lvl_n ({rd_n, wr_n}),
        .fall  (falls)
    );

    assign req.push   = falls[0];
    assign req.pop    = falls[1];
    assign req.rewind = !rt_n && wr_n && rd_n;

    fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .req      (req),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .is_empty (empty),
        .is_full  (full),
        .is_half  (is_half),
        .wrap_tok (wrap_tok)
    );

    fifo_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) oe_q <= 1'b0;
        else     oe_q <= !rd_n;
    end

    assign dout_oe  = oe_q;
    assign dout     = oe_q ? rd_data : '0;
    assign stat_pin = (mode == MODE_CHAIN) ? wrap_tok : is_half;

endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk (
    input logic       clk,
    input logic       rst,
    input logic       chain_mode,
    input logic       wr_n,
    input logic       rd_n,
    input logic       rt_n,
    input logic [8:0] dout,
    input logic       dout_oe,
    input logic       empty,
    input logic       full,
    input logic       stat_pin
);

    p_rst_state_r1: assert property (@(posedge clk)
        rst |=> (empty && !full && !dout_oe));

    p_oe_on_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_n |=> dout_oe);

    p_oe_off_r4: assert property (@(posedge clk) disable iff (rst)
        rd_n |=> !dout_oe);

    p_quiet_bus_r4: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> (dout == '0));

    p_flag_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    p_full_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (full && rd_n && rt_n) |=> full);

    p_empty_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_n && rt_n) |=> empty);

    p_half_when_full_r7: assert property (@(posedge clk) disable iff (rst)
        (!chain_mode && full) |-> stat_pin);

    p_token_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (chain_mode && stat_pin) |=> (!stat_pin || !chain_mode));

endmodule

bind strobe_fifo strobe_fifo_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .chain_mode (chain_mode),
    .wr_n       (wr_n),
    .rd_n       (rd_n),
    .rt_n       (rt_n),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .empty      (empty),
    .full       (full),
    .stat_pin   (stat_pin)
);

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;

    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chain_mode = 1'b0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       rt_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_oe, empty, full, stat_pin;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    strobe_fifo #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .chain_mode(chain_mode),
        .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din),
        .dout(dout), .dout_oe(dout_oe), .empty(empty), .full(full),
        .stat_pin(stat_pin)
    );

    task automatic check(input string req, input string what,
                         input logic [8:0] act, input logic [8:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic chain);
        @(negedge clk);
        rst = 1'b1; chain_mode = chain;
        wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic [8:0] d);
        @(negedge clk);
        din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
    endtask

    task automatic pop(output logic [8:0] d);
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        d = dout;
        rd_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        check("R1", "empty", 9'(empty), 9'd1);
        check("R1", "full", 9'(full), 9'd0);
        check("R1", "stat", 9'(stat_pin), 9'd0);
        check("R1", "oe", 9'(dout_oe), 9'd0);
    endtask

    task automatic t_hold_low;
        logic [8:0] d;
        do_reset(1'b0);
        @(negedge clk);
        din = 9'h011; wr_n = 1'b0;
        @(negedge clk);
        din = 9'h022;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        pop(d);
        check("R2", "held strobe word", d, 9'h011);
        check("R2", "single word stored", 9'(empty), 9'd1);
    endtask

    task automatic t_order_oe;
        logic [8:0] d;
        do_reset(1'b0);
        for (int i = 0; i < 5; i++) push(9'(9'h100 + i * 3));
        for (int i = 0; i < 5; i++) begin
            pop(d);
            check("R3", "order", d, 9'(9'h100 + i * 3));
            check("R4", "oe during read", 9'(dout_oe), 9'd1);
        end
        @(negedge clk);
        check("R4", "oe after read", 9'(dout_oe), 9'd0);
        check("R4", "bus zero", dout, 9'd0);
    endtask

    task automatic t_full;
        logic [8:0] d;
        do_reset(1'b0);
        for (int i = 0; i < DEPTH; i++) push(9'(i + 1));
        check("R5", "full set", 9'(full), 9'd1);
        push(9'h1FF);
        check("R5", "full held", 9'(full), 9'd1);
        for (int i = 0; i < DEPTH; i++) begin
            pop(d);
            if (i == 0 || i == DEPTH - 1)
                check("R5", "data survives blocked write", d, 9'(i + 1));
        end
        check("R5", "drained empty", 9'(empty), 9'd1);
    endtask

    task automatic t_empty_read;
        logic [8:0] d;
        do_reset(1'b0);
        pop(d);
        check("R6", "empty held", 9'(empty), 9'd1);
        push(9'h055);
        pop(d);
        check("R6", "next word after underrun", d, 9'h055);
        check("R6", "empty again", 9'(empty), 9'd1);
    endtask

    task automatic t_half;
        logic [8:0] d;
        do_reset(1'b0);
        for (int i = 0; i < DEPTH / 2 - 1; i++) push(9'(i));
        check("R7", "below half", 9'(stat_pin), 9'd0);
        push(9'h0AA);
        check("R7", "at half", 9'(stat_pin), 9'd1);
        pop(d);
        check("R7", "back below half", 9'(stat_pin), 9'd0);
    endtask

    task automatic t_rewind;
        logic [8:0] d;
        do_reset(1'b0);
        for (int i = 0; i < 5; i++) push(9'(9'h0A0 + i));
        pop(d); pop(d);
        @(negedge clk); rt_n = 1'b0;
        @(negedge clk); rt_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            pop(d);
            check("R8", "replayed word", d, 9'(9'h0A0 + i));
        end
        check("R8", "empty after replay", 9'(empty), 9'd1);
        push(9'h0F0);
        pop(d);
        check("R8", "write address kept", d, 9'h0F0);
    endtask

    task automatic t_rewind_ignored;
        logic [8:0] d;
        do_reset(1'b0);
        for (int i = 0; i < 3; i++) push(9'(9'h030 + i));
        pop(d);
        @(negedge clk); rd_n = 1'b0; rt_n = 1'b0;
        @(negedge clk);
        d = dout; rd_n = 1'b1; rt_n = 1'b1;
        check("R9", "read with rewind low", d, 9'h031);
        pop(d);
        check("R9", "no rewind with strobe low", d, 9'h032);
        check("R9", "empty", 9'(empty), 9'd1);
        do_reset(1'b1);
        for (int i = 0; i < 3; i++) push(9'(9'h040 + i));
        pop(d);
        @(negedge clk); rt_n = 1'b0;
        @(negedge clk); rt_n = 1'b1;
        pop(d);
        check("R9", "no rewind in chain mode", d, 9'h041);
    endtask

    task automatic t_token;
        do_reset(1'b1);
        for (int i = 0; i < DEPTH - 1; i++) begin
            push(9'(i));
            if (i == DEPTH / 2) check("R10", "no half flag in chain", 9'(stat_pin), 9'd0);
        end
        check("R10", "no token before last", 9'(stat_pin), 9'd0);
        push(9'h1EE);
        check("R10", "token after last address", 9'(stat_pin), 9'd1);
        @(negedge clk);
        check("R10", "token one cycle", 9'(stat_pin), 9'd0);
    endtask

    task automatic t_both;
        logic [8:0] d;
        do_reset(1'b0);
        push(9'h001); push(9'h002);
        @(negedge clk); din = 9'h003; wr_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        d = dout; wr_n = 1'b1; rd_n = 1'b1;
        check("R11", "oldest on joint strobe", d, 9'h001);
        pop(d);
        check("R11", "second", d, 9'h002);
        pop(d);
        check("R11", "third", d, 9'h003);
        check("R11", "occupancy kept", 9'(empty), 9'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_hold_low();
        t_order_oe();
        t_full();
        t_empty_read();
        t_half();
        t_rewind();
        t_rewind_ignored();
        t_token();
        t_both();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule